// File: doc/BRIEF.md
# Echo-Based Bus Contention Controller

This block sits beside a serial transmitter that shares a bus with other stations. The bus reflects every bit it carries back on an echo line. Before a frame may start, the block has to see an unbroken run of idle ones on the echo line. The frame's priority class sets the length of that run. A station that has just finished a frame cleanly must wait a little longer, which lets the other stations take a turn.

The transmitter only raises a start request, together with the priority class of its frame. It then waits for a one-cycle grant. While the frame is on the bus, the block compares each transmitted bit with its echo. On the first mismatch it flags a collision, which sends the transmitter back to listening. The transmitter marks the last bit of a clean frame with a done strobe. Everything advances on a bit strobe, `bit_en`. When contention handling is disabled, the block grants on any strobe that has a request pending, and its busy output shows a static configured level.

State machine:
- **LISTEN** counts consecutive echo ones.
  - Transition *grant*: a strobe with a request pending and the count at or above the threshold moves the block to SEND.
- **SEND** watches the echo.
  - Transition *collide*: a mismatch returns the block to LISTEN, with the penalty cleared.
  - Transition *finish*: a done strobe on a matching bit returns the block to LISTEN, with the penalty armed.
- *bypass*: a strobe while disabled forces the block to LISTEN.

Top module: `csma_echo_ctrl`

## Requirements
- R1: After reset `grant_o` and `collision_o` are 0, and `busy_o` is 0 while `csma_en`=1.
- R2: In LISTEN, a strobe with `echo_i`=0 resets the ones count to zero, so only consecutive ones count.
- R3: Without an armed penalty, the threshold is 8 when `pri_hi`=0 and 10 when `pri_hi`=1.
- R4: With the penalty armed, the threshold rises by 1 when `pen_small`=1 and by 2 when `pen_small`=0.
- R5: The grant condition is checked on a strobe in LISTEN, using the count of ones seen before that strobe. If `req_i`=1 and the count is at or above the threshold, `grant_o` is 1 for exactly the next clock cycle, the block enters SEND, and `busy_o`=1.
- R6: On a strobe in SEND where `tx_bit_i` differs from `echo_i`, `collision_o` pulses for one cycle and the block returns to LISTEN with the count at zero and the penalty cleared.
- R7: On a strobe in SEND where the bits match and `tx_done_i`=1, the block returns to LISTEN with the count at zero and the penalty armed, and `busy_o` returns to 0.
- R8: The ones count saturates at 12. After any longer idle run, a threshold of 12 is still met.
- R9: With `csma_en`=0, `busy_o` equals `static_cb`, and every strobe with `req_i`=1 grants. No collision is raised, and the penalty and count are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per bus bit |
| csma_en | input | 1 | 1 enables contention handling |
| static_cb | input | 1 | Busy level used while disabled |
| pen_small | input | 1 | Penalty select: 1 adds one, 0 adds two |
| pri_hi | input | 1 | Priority class of pending frame: 0 = 8, 1 = 10 |
| req_i | input | 1 | Start request from transmitter |
| tx_bit_i | input | 1 | Bit driven onto the bus this strobe |
| tx_done_i | input | 1 | Marks the last bit of the frame |
| echo_i | input | 1 | Bit echoed back from the bus |
| grant_o | output | 1 | One-cycle permission to start |
| collision_o | output | 1 | One-cycle collision indication |
| busy_o | output | 1 | Contention/busy output |

## Verification
The bench uses the default parameters: priority classes of 8 and 10, penalties of 1 and 2, and saturation at 12. With these values, the largest threshold equals the saturation point exactly. An idle run of 20 ones would wrap a 4-bit counter below 12, so that run tells a saturating counter apart from a wrapping one. A bit strobe every fourth clock leaves quiet cycles, which let the bench confirm that each grant lasts a single cycle.

// File: rtl/csma_pkg.sv
package csma_pkg;
    typedef enum logic [0:0] {
        ST_LISTEN = 1'b0,
        ST_SEND   = 1'b1
    } csma_st_e;
endpackage

// File: rtl/csma_ones_cnt.sv
module csma_ones_cnt #(
    parameter int SAT = 12,
    parameter int W   = $clog2(SAT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         one,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] SAT_W = W'(SAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            if (!one) begin
                cnt <= '0;
            end else if (cnt < SAT_W) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/csma_thresh.sv
module csma_thresh #(
    parameter int PRI_LO    = 8,
    parameter int PRI_HI    = 10,
    parameter int PEN_SMALL = 1,
    parameter int PEN_LARGE = 2,
    parameter int W         = 4
) (
    input  logic         pri_hi,
    input  logic         pen_armed,
    input  logic         pen_small,
    output logic [W-1:0] thr
);
    localparam logic [W-1:0] LO_W = W'(PRI_LO);
    localparam logic [W-1:0] HI_W = W'(PRI_HI);
    localparam logic [W-1:0] PS_W = W'(PEN_SMALL);
    localparam logic [W-1:0] PL_W = W'(PEN_LARGE);

    logic [W-1:0] base;
    logic [W-1:0] extra;

    always_comb begin
        base  = pri_hi ? HI_W : LO_W;
        extra = '0;
        if (pen_armed) begin
            extra = pen_small ? PS_W : PL_W;
        end
        thr = base + extra;
    end
endmodule

// File: rtl/csma_echo_ctrl.sv
module csma_echo_ctrl
    import csma_pkg::*;
#(
    parameter int PRI_LO    = 8,
    parameter int PRI_HI    = 10,
    parameter int PEN_SMALL = 1,
    parameter int PEN_LARGE = 2,
    parameter int CNT_SAT   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic csma_en,
    input  logic static_cb,
    input  logic pen_small,
    input  logic pri_hi,
    input  logic req_i,
    input  logic tx_bit_i,
    input  logic tx_done_i,
    input  logic echo_i,
    output logic grant_o,
    output logic collision_o,
    output logic busy_o
);
    localparam int CW = $clog2(CNT_SAT + 1);

    csma_st_e     st, st_nx;
    logic         pen_q, pen_nx;
    logic         grant_nx, coll_nx;
    logic         cnt_clr, cnt_step;
    logic [CW-1:0] ones_cnt;
    logic [CW-1:0] thr;

    csma_ones_cnt #(.SAT(CNT_SAT), .W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (cnt_step),
        .one   (echo_i),
        .cnt   (ones_cnt)
    );

    csma_thresh #(
        .PRI_LO(PRI_LO), .PRI_HI(PRI_HI),
        .PEN_SMALL(PEN_SMALL), .PEN_LARGE(PEN_LARGE), .W(CW)
    ) u_thr (
        .pri_hi    (pri_hi),
        .pen_armed (pen_q),
        .pen_small (pen_small),
        .thr       (thr)
    );

    // next-state and transition decode
    always_comb begin
        st_nx    = st;
        pen_nx   = pen_q;
        grant_nx = 1'b0;
        coll_nx  = 1'b0;
        cnt_clr  = 1'b0;
        cnt_step = 1'b0;
        if (bit_en) begin
            if (!csma_en) begin
                // bypass
                st_nx    = ST_LISTEN;
                pen_nx   = 1'b0;
                cnt_clr  = 1'b1;
                grant_nx = req_i;
            end else begin
                unique case (st)
                    ST_LISTEN: begin
                        if (req_i && (ones_cnt >= thr)) begin
                            st_nx    = ST_SEND;   // grant
                            grant_nx = 1'b1;
                            cnt_clr  = 1'b1;
                        end else begin
                            cnt_step = 1'b1;
                        end
                    end
                    ST_SEND: begin
                        cnt_clr = 1'b1;
                        if (tx_bit_i != echo_i) begin
                            st_nx   = ST_LISTEN;  // collide
                            coll_nx = 1'b1;
                            pen_nx  = 1'b0;
                        end else if (tx_done_i) begin
                            st_nx  = ST_LISTEN;   // finish
                            pen_nx = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_LISTEN;
            pen_q <= 1'b0;
        end else begin
            st    <= st_nx;
            pen_q <= pen_nx;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o     <= 1'b0;
            collision_o <= 1'b0;
        end else begin
            grant_o     <= grant_nx;
            collision_o <= coll_nx;
        end
    end

    assign busy_o = csma_en ? (st == ST_SEND) : static_cb;
endmodule

// File: rtl/csma_echo_ctrl_chk.sv
module csma_echo_ctrl_chk #(
    parameter int SAT = 12,
    parameter int W   = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bit_en,
    input logic         csma_en,
    input logic         req_i,
    input logic         tx_bit_i,
    input logic         echo_i,
    input logic         grant_o,
    input logic         collision_o,
    input logic         busy_o,
    input logic [W-1:0] cnt
);
    a_r5_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> $past(bit_en && req_i));

    a_r5_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !bit_en) |=> !grant_o);

    a_r5_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && csma_en && $past(csma_en)) |-> busy_o);

    a_r6_coll_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        collision_o |-> $past(bit_en && csma_en && (tx_bit_i != echo_i)));

    a_r6_coll_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (collision_o && csma_en) |-> !busy_o);

    a_r2_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !echo_i) |=> (cnt == '0));

    a_r8_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(SAT));

    a_r6_no_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && collision_o));
endmodule

bind csma_echo_ctrl csma_echo_ctrl_chk #(.SAT(CNT_SAT), .W(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .csma_en     (csma_en),
    .req_i       (req_i),
    .tx_bit_i    (tx_bit_i),
    .echo_i      (echo_i),
    .grant_o     (grant_o),
    .collision_o (collision_o),
    .busy_o      (busy_o),
    .cnt         (ones_cnt)
);

// File: tb/csma_echo_ctrl_tb.sv
`timescale 1ns/1ps
module csma_echo_ctrl_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, bit_en = 1'b0, csma_en = 1'b1, static_cb = 1'b0;
    logic pen_small = 1'b0, pri_hi = 1'b0, req_i = 1'b0;
    logic tx_bit_i = 1'b0, tx_done_i = 1'b0, echo_i = 1'b1;
    logic grant_o, collision_o, busy_o;

    int n_cmp = 0, n_err = 0;

    // reference model state
    bit m_send = 0, m_pen = 0;
    int m_cnt = 0;

    csma_echo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .csma_en(csma_en),
        .static_cb(static_cb), .pen_small(pen_small), .pri_hi(pri_hi),
        .req_i(req_i), .tx_bit_i(tx_bit_i), .tx_done_i(tx_done_i),
        .echo_i(echo_i), .grant_o(grant_o), .collision_o(collision_o),
        .busy_o(busy_o)
    );

    function automatic int exp_thr(bit ph, bit armed, bit ps);
        int t;
        t = ph ? 10 : 8;
        if (armed) t += ps ? 1 : 2;
        return t;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    // one bus bit: drive, model, compare
    task automatic step(string tag, logic e, logic r, logic tb, logic d);
        bit eg, ec, eb;
        eg = 0; ec = 0;
        if (!csma_en) begin
            eg = r; m_send = 0; m_pen = 0; m_cnt = 0;
        end else if (!m_send) begin
            if (r && m_cnt >= exp_thr(pri_hi, m_pen, pen_small)) begin
                eg = 1; m_send = 1; m_cnt = 0;
            end else if (!e) m_cnt = 0;
            else if (m_cnt < 12) m_cnt++;
        end else begin
            m_cnt = 0;
            if (tb != e) begin ec = 1; m_send = 0; m_pen = 0; end
            else if (d) begin m_send = 0; m_pen = 1; end
        end
        eb = csma_en ? m_send : static_cb;
        @(negedge clk);
        echo_i = e; req_i = r; tx_bit_i = tb; tx_done_i = d; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        chk({tag, " grant (R5)"}, grant_o, eg);
        chk({tag, " collision (R6)"}, collision_o, ec);
        chk({tag, " busy (R7)"}, busy_o, eb);
        @(negedge clk);
        chk({tag, " grant one cycle (R5)"}, grant_o, 1'b0);
        @(negedge clk);
    endtask

    task automatic ones(string tag, int n, logic r);
        for (int i = 0; i < n; i++) step(tag, 1'b1, r, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C5A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset grant", grant_o, 1'b0);
        chk("R1 reset collision", collision_o, 1'b0);
        chk("R1 reset busy", busy_o, 1'b0);

        // R2: a zero breaks the run
        pri_hi = 0;
        ones("R2 run", 5, 1'b0);
        step("R2 zero", 1'b0, 1'b0, 1'b0, 1'b0);
        ones("R2 after zero", 7, 1'b1);
        step("R2 not yet", 1'b1, 1'b1, 1'b0, 1'b0);
        // R3: 8 ones counted, next strobe grants
        step("R3 pri8 grant", 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R3 granted into send", busy_o, 1'b1);
        // R7: clean frame end
        step("R7 bit", 1'b0, 1'b0, 1'b0, 1'b0);
        step("R7 done", 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R7 busy low after done", busy_o, 1'b0);
        // R4: penalty +1 -> 9
        pen_small = 1;
        ones("R4 pen1", 9, 1'b1);
        step("R4 pen1 grant", 1'b1, 1'b1, 1'b0, 1'b0);
        // R6: mismatch
        step("R6 mismatch", 1'b0, 1'b0, 1'b1, 1'b0);
        ones("R6 pri8 again", 8, 1'b1);
        step("R6 no-penalty grant", 1'b1, 1'b1, 1'b0, 1'b0);
        step("R6 finish", 1'b1, 1'b0, 1'b1, 1'b1);
        // R4 pen2 + R3 pri10 + R8 saturation: threshold 12
        pen_small = 0; pri_hi = 1;
        ones("R8 long idle", 20, 1'b0);
        step("R8 sat grant", 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8 grant after 20 ones", busy_o, 1'b1);
        step("R8 finish", 1'b0, 1'b0, 1'b0, 1'b1);
        ones("R4 pen2", 12, 1'b1);
        step("R4 pen2 grant", 1'b1, 1'b1, 1'b0, 1'b0);
        // R9: bypass
        csma_en = 0; static_cb = 1;
        step("R9 bypass grant", 1'b0, 1'b1, 1'b1, 1'b0);
        step("R9 no collision", 1'b0, 1'b1, 1'b1, 1'b0);
        static_cb = 0;
        step("R9 static low", 1'b0, 1'b0, 1'b0, 1'b0);
        csma_en = 1;
        ones("R9 penalty cleared", 10, 1'b1);
        step("R9 pri10 grant", 1'b1, 1'b1, 1'b0, 1'b0);

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            logic e, r, tb, d;
            if (k % 40 == 0) begin
                pri_hi = 1'($urandom); pen_small = 1'($urandom);
                csma_en = ($urandom % 8) != 0; static_cb = 1'($urandom);
            end
            tb = 1'($urandom);
            d  = ($urandom % 6) == 0;
            r  = 1'($urandom);
            if (m_send && csma_en) e = (($urandom % 10) == 0) ? ~tb : tb;
            else e = ($urandom % 12) != 0;
            step("R5 random", e, r, tb, d);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule